// File: doc/BRIEF.md
# Segmented Operand Address Generator

This unit turns the addressing byte that follows a two-operand opcode into an operand location. When the byte's mode field selects a register operand, the unit reports a register-direct result and the register index. Otherwise it gathers zero, one or two displacement bytes from the instruction stream. It adds the displacement to the base and index registers that the byte names, then chooses the default segment. It returns the segment, the 16-bit offset and the 20-bit physical address, where the physical address is the segment shifted left four bits plus the offset.

An operation starts with a one-cycle `start` strobe that carries the addressing byte. Displacement bytes then arrive on a valid-qualified byte stream, least significant byte first, with any number of idle cycles between them. One clock edge after the last needed byte is taken, the result is captured from the live register inputs and `addrValid` pulses for one cycle. The register inputs must therefore be stable during that capture cycle. Prefix handling, instruction fetch and the register file sit outside the unit.

Top module: `modrm_addr_unit`

## Requirements
- R1: After reset, `busy`, `addrValid`, `regDirect`, `regIdx`, `segIdx`, `segOut`, `offsetOut`, `physAddr` and `dispCount` are all zero.
- R2: When the addressing byte has its two top bits equal to 11, the result has `regDirect`=1, takes no displacement bytes (`dispCount`=0), and reports `segOut`, `offsetOut` and `physAddr` as zero.
- R3: With mode bits 00 and the low three bits `b` not equal to 6, the offset is, by `b`: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 7 BX. No displacement byte is taken.
- R4: The segment is SS (`ssIn`) for the BP-based forms (b = 2, 3, and 6 when not the direct form) and DS (`dsIn`) for every other memory form.
- R5: Mode bits 01 take one displacement byte and add it to the base sum after sign extension to 16 bits (`dispCount`=1).
- R6: Mode bits 10 take two displacement bytes, low byte first, and add the 16-bit value to the base sum (`dispCount`=2).
- R7: An addressing byte whose bits 7:6 are 00 and bits 2:0 are 110 is the direct form: the offset is the two following bytes (low first) with no register added, the segment is DS, and `dispCount`=2.
- R8: The offset wraps modulo 2^16, and `physAddr` = (`segOut`·16 + `offsetOut`) mod 2^20.
- R9: `regIdx` always equals bits 5:3 of the addressing byte and `segIdx` always equals bits 4:3, for memory and register forms alike.
- R10: `addrValid` is high for exactly one cycle. It goes high on the first clock edge after the edge that took the last needed displacement byte, or after the start edge when no byte is needed.
- R11: `dispValid` strobes while the unit is idle are ignored, and `start` while `busy` is high is ignored. Neither changes the result that is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Addressing byte valid; taken only while idle |
| modrmIn | input | 8 | Addressing byte |
| dispValid | input | 1 | Displacement byte valid |
| dispByte | input | 8 | Displacement byte, low byte first |
| bxIn | input | 16 | BX register value |
| bpIn | input | 16 | BP register value |
| siIn | input | 16 | SI register value |
| diIn | input | 16 | DI register value |
| dsIn | input | 16 | DS segment value |
| ssIn | input | 16 | SS segment value |
| busy | output | 1 | An operation is in progress |
| addrValid | output | 1 | One-cycle result strobe |
| regDirect | output | 1 | Result selects a register operand |
| regIdx | output | 3 | Register index (bits 5:3) |
| segIdx | output | 2 | Segment register index (bits 4:3) |
| segOut | output | 16 | Chosen segment value |
| offsetOut | output | 16 | Effective offset |
| physAddr | output | 20 | Physical address |
| dispCount | output | 2 | Displacement bytes consumed |

## Verification
The main function is driven with random addressing bytes across all four mode values, random register contents and random gaps between displacement bytes. This separates mistakes in the base-index table, the segment choice, the displacement width and the byte order. Directed cases use an addressing byte that carries non-zero register bits in the direct form, which shows whether the direct form is recognised by mode and base bits alone. A negative 8-bit displacement shows whether sign extension is done. Offsets and segments near 0xFFFF show that the 16-bit offset and the 20-bit address each wrap. Stray `dispValid` pulses before an operation and a second `start` in the middle of one show whether the sequencer lets either change the result.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_S8   = 2'd1,
    DISP_W16  = 2'd2
  } dispMode_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchOp;
    logic takeLo;
    logic takeHi;
    logic capture;
  } aguStrobe_t;

  // decoded view of an addressing byte
  typedef struct packed {
    logic      regDirect;
    logic      directAddr;
    logic      useSs;
    logic      useBx;
    logic      useBp;
    logic      useSi;
    logic      useDi;
    dispMode_t dispMode;
    logic [1:0] needBytes;
  } aguDecode_t;

endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [7:0]  modrm,
  output aguDecode_t  dec
);

  logic [1:0] modField;
  logic [2:0] rmField;

  assign modField = modrm[7:6];
  assign rmField  = modrm[2:0];

  always_comb begin
    dec = '0;
    dec.regDirect  = (modField == 2'b11);
    dec.directAddr = (modField == 2'b00) && (rmField == 3'd6);

    unique case (modField)
      2'b00:   dec.dispMode = dec.directAddr ? DISP_W16 : DISP_NONE;
      2'b01:   dec.dispMode = DISP_S8;
      2'b10:   dec.dispMode = DISP_W16;
      default: dec.dispMode = DISP_NONE;
    endcase

    unique case (dec.dispMode)
      DISP_S8:  dec.needBytes = 2'd1;
      DISP_W16: dec.needBytes = 2'd2;
      default:  dec.needBytes = 2'd0;
    endcase

    // base and index terms; the direct form uses none of them
    if (!dec.regDirect && !dec.directAddr) begin
      unique case (rmField)
        3'd0: begin dec.useBx = 1'b1; dec.useSi = 1'b1; end
        3'd1: begin dec.useBx = 1'b1; dec.useDi = 1'b1; end
        3'd2: begin dec.useBp = 1'b1; dec.useSi = 1'b1; end
        3'd3: begin dec.useBp = 1'b1; dec.useDi = 1'b1; end
        3'd4: dec.useSi = 1'b1;
        3'd5: dec.useDi = 1'b1;
        3'd6: dec.useBp = 1'b1;
        default: dec.useBx = 1'b1;
      endcase
    end

    // stack segment for every frame-pointer-based form
    dec.useSs = dec.useBp;
  end

endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dispValid,
  input  logic [1:0] needBytes,
  output aguStrobe_t stb,
  output logic       busy
);

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_GATHER = 1'b1
  } ctrlState_t;

  ctrlState_t state;
  logic [1:0] gotBytes;
  logic       allIn;

  assign allIn = (gotBytes == needBytes);
  assign busy  = (state == ST_GATHER);

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE:   stb.latchOp = start;
      default: begin
        stb.capture = allIn;
        stb.takeLo  = !allIn && dispValid && (gotBytes == 2'd0);
        stb.takeHi  = !allIn && dispValid && (gotBytes == 2'd1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gotBytes <= 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_GATHER;
            gotBytes <= 2'd0;
          end
        end
        default: begin
          if (allIn) begin
            state <= ST_IDLE;
          end else if (dispValid) begin
            gotBytes <= gotBytes + 2'd1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = DATA_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobe_t        stb,
  input  logic [7:0]        modrmIn,
  input  logic [7:0]        dispByte,
  input  logic [DATA_W-1:0] bxIn,
  input  logic [DATA_W-1:0] bpIn,
  input  logic [DATA_W-1:0] siIn,
  input  logic [DATA_W-1:0] diIn,
  input  logic [DATA_W-1:0] dsIn,
  input  logic [DATA_W-1:0] ssIn,
  output logic [1:0]        needBytes,
  output logic              addrValid,
  output logic              regDirect,
  output logic [2:0]        regIdx,
  output logic [1:0]        segIdx,
  output logic [DATA_W-1:0] segOut,
  output logic [DATA_W-1:0] offsetOut,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        dispCount
);

  logic [7:0]        opReg;
  logic [7:0]        dispLo;
  logic [7:0]        dispHi;
  aguDecode_t        dec;
  logic [DATA_W-1:0] dispShort;
  logic [DATA_W-1:0] dispWord;
  logic [DATA_W-1:0] dispExt;
  logic [DATA_W-1:0] baseSum;
  logic [DATA_W-1:0] offsetNext;
  logic [DATA_W-1:0] segNext;
  logic [PHYS_W-1:0] physNext;

  agu_decode u_dec (
    .modrm (opReg),
    .dec   (dec)
  );

  assign needBytes = dec.needBytes;

  // displacement widening; the word form needs padding only when wider than 16
  assign dispShort = {{(DATA_W-8){dispLo[7]}}, dispLo};
  generate
    if (DATA_W == 16) begin : g_wordExact
      assign dispWord = {dispHi, dispLo};
    end else begin : g_wordPad
      assign dispWord = {{(DATA_W-16){1'b0}}, dispHi, dispLo};
    end
  endgenerate

  always_comb begin
    unique case (dec.dispMode)
      DISP_S8:  dispExt = dispShort;
      DISP_W16: dispExt = dispWord;
      default:  dispExt = '0;
    endcase
  end

  always_comb begin
    baseSum = '0;
    if (dec.useBx) baseSum = baseSum + bxIn;
    if (dec.useBp) baseSum = baseSum + bpIn;
    if (dec.useSi) baseSum = baseSum + siIn;
    if (dec.useDi) baseSum = baseSum + diIn;
  end

  assign offsetNext = baseSum + dispExt;
  assign segNext    = dec.useSs ? ssIn : dsIn;
  assign physNext   = {segNext, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offsetNext};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      dispLo <= '0;
      dispHi <= '0;
    end else begin
      if (stb.latchOp) opReg  <= modrmIn;
      if (stb.takeLo)  dispLo <= dispByte;
      if (stb.takeHi)  dispHi <= dispByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      regDirect <= 1'b0;
      regIdx    <= '0;
      segIdx    <= '0;
      segOut    <= '0;
      offsetOut <= '0;
      physAddr  <= '0;
      dispCount <= '0;
    end else begin
      addrValid <= stb.capture;
      if (stb.capture) begin
        regDirect <= dec.regDirect;
        regIdx    <= opReg[5:3];
        segIdx    <= opReg[4:3];
        dispCount <= dec.needBytes;
        if (dec.regDirect) begin
          segOut    <= '0;
          offsetOut <= '0;
          physAddr  <= '0;
        end else begin
          segOut    <= segNext;
          offsetOut <= offsetNext;
          physAddr  <= physNext;
        end
      end
    end
  end

endmodule

// File: rtl/modrm_addr_unit.sv
module modrm_addr_unit
  import agu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = DATA_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        modrmIn,
  input  logic              dispValid,
  input  logic [7:0]        dispByte,
  input  logic [DATA_W-1:0] bxIn,
  input  logic [DATA_W-1:0] bpIn,
  input  logic [DATA_W-1:0] siIn,
  input  logic [DATA_W-1:0] diIn,
  input  logic [DATA_W-1:0] dsIn,
  input  logic [DATA_W-1:0] ssIn,
  output logic              busy,
  output logic              addrValid,
  output logic              regDirect,
  output logic [2:0]        regIdx,
  output logic [1:0]        segIdx,
  output logic [DATA_W-1:0] segOut,
  output logic [DATA_W-1:0] offsetOut,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        dispCount
);

  aguStrobe_t stb;
  logic [1:0] needBytes;

  agu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .dispValid (dispValid),
    .needBytes (needBytes),
    .stb       (stb),
    .busy      (busy)
  );

  agu_datapath #(
    .DATA_W    (DATA_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .modrmIn   (modrmIn),
    .dispByte  (dispByte),
    .bxIn      (bxIn),
    .bpIn      (bpIn),
    .siIn      (siIn),
    .diIn      (diIn),
    .dsIn      (dsIn),
    .ssIn      (ssIn),
    .needBytes (needBytes),
    .addrValid (addrValid),
    .regDirect (regDirect),
    .regIdx    (regIdx),
    .segIdx    (segIdx),
    .segOut    (segOut),
    .offsetOut (offsetOut),
    .physAddr  (physAddr),
    .dispCount (dispCount)
  );

endmodule

// File: rtl/modrm_addr_unit_chk.sv
module modrm_addr_unit_chk #(
  parameter int DATA_W    = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = DATA_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              addrValid,
  input logic              regDirect,
  input logic [1:0]        segIdx,
  input logic [2:0]        regIdx,
  input logic [DATA_W-1:0] segOut,
  input logic [DATA_W-1:0] offsetOut,
  input logic [PHYS_W-1:0] physAddr,
  input logic [1:0]        dispCount
);

  // R10: the result strobe never lasts two cycles
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  // R10: a result is only reported right after an operation was in progress
  a_r10_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> $past(busy));

  // R10: the sequencer leaving its busy state produces the strobe
  a_r10_done_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> addrValid);

  // R2: a register operand consumes no displacement and reports no address
  a_r2_reg_form: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && regDirect) |-> (dispCount == 2'd0 && physAddr == '0 && offsetOut == '0));

  // R8: the address is the shifted segment plus the offset, truncated
  a_r8_phys_sum: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !regDirect) |->
      (physAddr == PHYS_W'({segOut, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offsetOut})));

  // R9: the two index outputs share bits 4:3 of the same byte
  a_r9_idx_overlap: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (regIdx[1:0] == segIdx));

  // R2: results hold between strobes
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!addrValid && $past(rstN)) |-> $stable(physAddr));

endmodule

bind modrm_addr_unit modrm_addr_unit_chk #(
  .DATA_W    (DATA_W),
  .SEG_SHIFT (SEG_SHIFT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .addrValid (addrValid),
  .regDirect (regDirect),
  .segIdx    (segIdx),
  .regIdx    (regIdx),
  .segOut    (segOut),
  .offsetOut (offsetOut),
  .physAddr  (physAddr),
  .dispCount (dispCount)
);

// File: tb/sim_modrm_addr_unit.sv
module sim_modrm_addr_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  modrmIn = '0;
  logic        dispValid = 1'b0;
  logic [7:0]  dispByte = '0;
  logic [15:0] bxIn = '0, bpIn = '0, siIn = '0, diIn = '0, dsIn = '0, ssIn = '0;
  logic        busy, addrValid, regDirect;
  logic [2:0]  regIdx;
  logic [1:0]  segIdx, dispCount;
  logic [15:0] segOut, offsetOut;
  logic [19:0] physAddr;

  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  modrm_addr_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .modrmIn(modrmIn),
    .dispValid(dispValid), .dispByte(dispByte),
    .bxIn(bxIn), .bpIn(bpIn), .siIn(siIn), .diIn(diIn), .dsIn(dsIn), .ssIn(ssIn),
    .busy(busy), .addrValid(addrValid), .regDirect(regDirect), .regIdx(regIdx),
    .segIdx(segIdx), .segOut(segOut), .offsetOut(offsetOut), .physAddr(physAddr),
    .dispCount(dispCount)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int needOf(input logic [7:0] m);
    if (m[7:6] == 2'b11) return 0;
    if (m[7:6] == 2'b01) return 1;
    if (m[7:6] == 2'b10) return 2;
    if (m[2:0] == 3'd6) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] expOffset(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] b;
    logic [15:0] d;
    if (m[7:6] == 2'b00 && m[2:0] == 3'd6) return {hi, lo};
    case (m[2:0])
      3'd0: b = bxIn + siIn;
      3'd1: b = bxIn + diIn;
      3'd2: b = bpIn + siIn;
      3'd3: b = bpIn + diIn;
      3'd4: b = siIn;
      3'd5: b = diIn;
      3'd6: b = bpIn;
      default: b = bxIn;
    endcase
    if (m[7:6] == 2'b01) d = {{8{lo[7]}}, lo};
    else if (m[7:6] == 2'b10) d = {hi, lo};
    else d = 16'h0;
    return b + d;
  endfunction

  function automatic logic [15:0] expSeg(input logic [7:0] m);
    if (m[7:6] == 2'b00 && m[2:0] == 3'd6) return dsIn;
    if (m[2:0] == 3'd2 || m[2:0] == 3'd3 || m[2:0] == 3'd6) return ssIn;
    return dsIn;
  endfunction

  // one complete operation; gap = idle cycles before each byte, poke = second start mid-operation
  task automatic runOp(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input int gap, input bit poke);
    int n;
    logic [15:0] eOfs, eSeg;
    logic [19:0] ePhys;
    n = needOf(m);
    @(negedge clk);
    modrmIn = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    modrmIn = $urandom;
    chk("R10 busy after start", {31'b0, busy}, 32'd1);
    if (poke && n > 0) begin
      start = 1'b1;
      modrmIn = 8'hC0;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(negedge clk);
      dispValid = 1'b1;
      dispByte = (i == 0) ? lo : hi;
      @(negedge clk);
      dispValid = 1'b0;
      dispByte = $urandom;
    end
    chk("R10 no early strobe", {31'b0, addrValid}, 32'd0);
    @(negedge clk);
    chk("R10 strobe", {31'b0, addrValid}, 32'd1);
    chk("R9 regIdx", {29'b0, regIdx}, {29'b0, m[5:3]});
    chk("R9 segIdx", {30'b0, segIdx}, {30'b0, m[4:3]});
    chk("R2 regDirect", {31'b0, regDirect}, {31'b0, (m[7:6] == 2'b11)});
    chk("R5 R6 R7 dispCount", {30'b0, dispCount}, n);
    if (m[7:6] == 2'b11) begin
      eOfs = 16'h0; eSeg = 16'h0; ePhys = 20'h0;
    end else begin
      eOfs = expOffset(m, lo, hi);
      eSeg = expSeg(m);
      ePhys = 20'({eSeg, 4'h0} + {4'h0, eOfs});
    end
    chk("R3 R5 R6 R7 offset", {16'b0, offsetOut}, {16'b0, eOfs});
    chk("R4 segment", {16'b0, segOut}, {16'b0, eSeg});
    chk("R8 physAddr", {12'b0, physAddr}, {12'b0, ePhys});
    @(negedge clk);
    chk("R10 pulse ends", {31'b0, addrValid}, 32'd0);
  endtask

  task automatic setRegs(input logic [15:0] bx, bp, si, di, ds, ss);
    @(negedge clk);
    bxIn = bx; bpIn = bp; siIn = si; diIn = di; dsIn = ds; ssIn = ss;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 addrValid", {31'b0, addrValid}, 32'd0);
    chk("R1 outputs", {regDirect, regIdx, segIdx, dispCount, 4'b0, offsetOut}, 32'd0);
    chk("R1 seg phys", {segOut, physAddr[15:0]}, 32'd0);
    rstN = 1'b1;

    setRegs(16'h1111, 16'h2222, 16'h0300, 16'h0040, 16'h1000, 16'h2000);
    // R2 register forms
    runOp(8'hC0, 8'h00, 8'h00, 0, 1'b0);
    runOp(8'hEB, 8'h00, 8'h00, 0, 1'b0);
    runOp(8'hFF, 8'h00, 8'h00, 0, 1'b0);
    // R3 R4 every base form without displacement
    for (int r = 0; r < 8; r++) if (r != 6) runOp(8'(r) | 8'h18, 8'h00, 8'h00, 0, 1'b0);
    // R7 direct form, also with register bits set
    runOp(8'h06, 8'h34, 8'h12, 0, 1'b0);
    runOp(8'h3E, 8'hCD, 8'hAB, 2, 1'b0);
    // R5 negative short displacement, R4 frame-pointer form
    runOp(8'h46, 8'h80, 8'h00, 1, 1'b0);
    runOp(8'h40, 8'hFF, 8'h00, 0, 1'b0);
    // R6 word displacement low byte first
    runOp(8'h86, 8'h01, 8'h80, 0, 1'b0);
    // R8 offset and address wrap
    setRegs(16'hFFFF, 16'h0000, 16'h0003, 16'h0000, 16'hFFFF, 16'hFFFF);
    runOp(8'h00, 8'h00, 8'h00, 0, 1'b0);
    runOp(8'h87, 8'hFF, 8'hFF, 0, 1'b0);
    // R11 idle dispValid ignored, start mid-operation ignored
    @(negedge clk);
    dispValid = 1'b1; dispByte = 8'hEE;
    @(negedge clk);
    @(negedge clk);
    dispValid = 1'b0;
    chk("R11 idle bytes leave unit idle", {31'b0, busy}, 32'd0);
    runOp(8'h84, 8'h10, 8'h20, 0, 1'b0);
    runOp(8'h81, 8'h55, 8'h66, 1, 1'b1);
    runOp(8'h4A, 8'h7F, 8'h00, 0, 1'b1);

    // random mix
    for (int k = 0; k < 400; k++) begin
      setRegs($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      runOp($urandom, $urandom, $urandom, $urandom_range(0, 2), ($urandom_range(0, 4) == 0));
    end
    finishRun();
  end

endmodule